// File: doc/BRIEF.md
# Dual Byte-Wide Parallel I/O Port Controller

This block provides two 8-bit general-purpose pin ports, A and B, on a simple byte-wide register bus. Each port has a latch for the value to drive and a direction mask. The block registers the pin output values and output enables. It passes the pin inputs through a two-flop synchronizer and returns one registered read byte per cycle for whatever offset is on the bus.

Each pin can be handed to an alternate function through a per-pin select. When it is, the pin's enable and value come from the alternate source. Writes to the latch are still stored, but they do not reach that pin.

A mode input turns port B into the high byte of an external address bus. In that mode port B's registers leave the map: their offsets read zero and ignore writes. Their contents are kept for when the mode is dropped.

Top module: `pio_dual_port`

## Requirements
- R1: The registers are at these 3-bit offsets: 0 is the port A latch, 1 is the port A direction mask, 4 is the port B latch and 5 is the port B direction mask. A write is taken on a rising clock edge where `bus_wr` is 1 and `rst` is 0.
- R2: Take a pin with its alternate select at 0 and, for port B, the mode input at 0. Its output enable equals its direction bit, where 1 means output. Its output value is the latched bit when the direction bit is 1, and 0 when it is 0.
- R3: A synchronous reset clears both direction masks, both synchronizers, all pin enables and values, and the read byte.
- R4: Reset leaves both latches unchanged. A value written before reset appears on the pins once the direction bits are set after reset.
- R5: Reading a latch offset returns, per bit, the latched bit when the direction bit is 1 and the synchronized pin level when it is 0. A pin change made before edge k shows in `bus_rdata` after edge k+2.
- R6: A pin whose alternate select bit is 1 takes its output enable and value from the alternate inputs, whatever its direction bit. A latch write made meanwhile is still stored and can be read back.
- R7: With `exp_mode` at 1, every port B pin is enabled as an output and pin i drives `hi_addr[i]`, so bit 0 is A8 and bit 7 is A15. This takes effect one edge after the inputs change.
- R8: With `exp_mode` at 1, offsets 4 and 5 read as 0x00 and writes to them are dropped. After the mode returns to 0, both registers read back the values they held before.
- R9: Offsets 2, 3, 6 and 7 read as 0x00. Writes to them change no register.
- R10: `bus_rdata` reflects the offset and register state present before the edge that loads it. A register write reaches the pins one edge after the edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| exp_mode | input | 1 | 1 turns port B into the high address byte |
| hi_addr | input | 8 | High address byte driven on port B in that mode |
| pin_in_a | input | 8 | Port A pin levels (asynchronous) |
| pin_out_a | output | 8 | Port A pin drive values |
| pin_oe_a | output | 8 | Port A pin output enables |
| alt_sel_a | input | 8 | Port A per-pin alternate select |
| alt_oe_a | input | 8 | Port A alternate output enables |
| alt_out_a | input | 8 | Port A alternate output values |
| pin_in_b | input | 8 | Port B pin levels (asynchronous) |
| pin_out_b | output | 8 | Port B pin drive values |
| pin_oe_b | output | 8 | Port B pin output enables |
| alt_sel_b | input | 8 | Port B per-pin alternate select |
| alt_oe_b | input | 8 | Port B alternate output enables |
| alt_out_b | input | 8 | Port B alternate output values |

## Verification
The assertions check every cycle that:
- reset quiets the pins and the read byte;
- the direction mask drives port A's enables when no alternate is selected;
- alternate sources take over the pins they select;
- address mode drives port B from `hi_addr`;
- hidden and unmapped offsets read zero.

Only the bench's scenarios can show the properties that need history:
- latches surviving reset;
- writes stored behind an alternate function;
- port B registers reappearing intact after address mode;
- the exact two-edge synchronizer delay on reads.

A cycle-by-cycle reference model covers random traffic as well.

// File: rtl/pio_pkg.sv
package pio_pkg;
  // Register offsets; port B's pair is hidden in address mode
  localparam int unsigned OFS_A_DAT = 0;
  localparam int unsigned OFS_A_DIR = 1;
  localparam int unsigned OFS_B_DAT = 4;
  localparam int unsigned OFS_B_DIR = 5;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_A_DAT,
    SEL_A_DIR,
    SEL_B_DAT,
    SEL_B_DIR
  } rd_sel_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= '0;
    end else begin
      chain[0] <= d;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pio_port.sv
module pio_port #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] wdata,
  input  logic         wr_dat,
  input  logic         wr_dir,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] alt_sel,
  input  logic [W-1:0] alt_oe,
  input  logic [W-1:0] alt_out,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] rd_dat,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);
  logic [W-1:0] dat_q;
  logic [W-1:0] pin_s;
  logic [W-1:0] nxt_out;
  logic [W-1:0] nxt_oe;

  // Latch is deliberately outside the reset domain
  always_ff @(posedge clk) begin
    if (wr_dat) dat_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)         dir_q <= '0;
    else if (wr_dir) dir_q <= wdata;
  end

  pio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_s)
  );

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign rd_dat[i]  = dir_q[i] ? dat_q[i] : pin_s[i];
    assign nxt_oe[i]  = alt_sel[i] ? alt_oe[i]  : dir_q[i];
    assign nxt_out[i] = alt_sel[i] ? alt_out[i] : (dir_q[i] & dat_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_oe  <= '0;
      pin_out <= '0;
    end else begin
      pin_oe  <= nxt_oe;
      pin_out <= nxt_out;
    end
  end
endmodule

// File: rtl/pio_decode.sv
module pio_decode #(
  parameter int AW = 3
) (
  input  logic            rst,
  input  logic [AW-1:0]   addr,
  input  logic            wr,
  input  logic            exp_mode,
  output logic            wr_a_dat,
  output logic            wr_a_dir,
  output logic            wr_b_dat,
  output logic            wr_b_dir,
  output pio_pkg::rd_sel_e sel
);
  import pio_pkg::*;
  localparam logic [AW-1:0] A_DAT = AW'(OFS_A_DAT);
  localparam logic [AW-1:0] A_DIR = AW'(OFS_A_DIR);
  localparam logic [AW-1:0] B_DAT = AW'(OFS_B_DAT);
  localparam logic [AW-1:0] B_DIR = AW'(OFS_B_DIR);

  always_comb begin
    case (addr)
      A_DAT:   sel = SEL_A_DAT;
      A_DIR:   sel = SEL_A_DIR;
      B_DAT:   sel = exp_mode ? SEL_NONE : SEL_B_DAT;
      B_DIR:   sel = exp_mode ? SEL_NONE : SEL_B_DIR;
      default: sel = SEL_NONE;
    endcase
  end

  logic wr_ok;
  assign wr_ok    = wr & ~rst;
  assign wr_a_dat = wr_ok && (sel == SEL_A_DAT);
  assign wr_a_dir = wr_ok && (sel == SEL_A_DIR);
  assign wr_b_dat = wr_ok && (sel == SEL_B_DAT);
  assign wr_b_dir = wr_ok && (sel == SEL_B_DIR);
endmodule

// File: rtl/pio_dual_port.sv
module pio_dual_port #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              exp_mode,
  input  logic [DATA_W-1:0] hi_addr,
  input  logic [DATA_W-1:0] pin_in_a,
  output logic [DATA_W-1:0] pin_out_a,
  output logic [DATA_W-1:0] pin_oe_a,
  input  logic [DATA_W-1:0] alt_sel_a,
  input  logic [DATA_W-1:0] alt_oe_a,
  input  logic [DATA_W-1:0] alt_out_a,
  input  logic [DATA_W-1:0] pin_in_b,
  output logic [DATA_W-1:0] pin_out_b,
  output logic [DATA_W-1:0] pin_oe_b,
  input  logic [DATA_W-1:0] alt_sel_b,
  input  logic [DATA_W-1:0] alt_oe_b,
  input  logic [DATA_W-1:0] alt_out_b
);
  import pio_pkg::*;

  logic wr_a_dat, wr_a_dir, wr_b_dat, wr_b_dir;
  rd_sel_e sel;
  logic [DATA_W-1:0] dir_a, dir_b, rd_a, rd_b;
  logic [DATA_W-1:0] b_sel, b_oe, b_out;
  logic [DATA_W-1:0] rd_nxt;

  pio_decode #(.AW(ADDR_W)) u_dec (
    .rst      (rst),
    .addr     (bus_addr),
    .wr       (bus_wr),
    .exp_mode (exp_mode),
    .wr_a_dat (wr_a_dat),
    .wr_a_dir (wr_a_dir),
    .wr_b_dat (wr_b_dat),
    .wr_b_dir (wr_b_dir),
    .sel      (sel)
  );

  pio_port #(.W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_port_a (
    .clk     (clk),
    .rst     (rst),
    .wdata   (bus_wdata),
    .wr_dat  (wr_a_dat),
    .wr_dir  (wr_a_dir),
    .pin_in  (pin_in_a),
    .alt_sel (alt_sel_a),
    .alt_oe  (alt_oe_a),
    .alt_out (alt_out_a),
    .dir_q   (dir_a),
    .rd_dat  (rd_a),
    .pin_out (pin_out_a),
    .pin_oe  (pin_oe_a)
  );

  // Address mode overrides every port B pin with the high address byte
  assign b_sel = exp_mode ? {DATA_W{1'b1}} : alt_sel_b;
  assign b_oe  = exp_mode ? {DATA_W{1'b1}} : alt_oe_b;
  assign b_out = exp_mode ? hi_addr        : alt_out_b;

  pio_port #(.W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_port_b (
    .clk     (clk),
    .rst     (rst),
    .wdata   (bus_wdata),
    .wr_dat  (wr_b_dat),
    .wr_dir  (wr_b_dir),
    .pin_in  (pin_in_b),
    .alt_sel (b_sel),
    .alt_oe  (b_oe),
    .alt_out (b_out),
    .dir_q   (dir_b),
    .rd_dat  (rd_b),
    .pin_out (pin_out_b),
    .pin_oe  (pin_oe_b)
  );

  always_comb begin
    case (sel)
      SEL_A_DAT: rd_nxt = rd_a;
      SEL_A_DIR: rd_nxt = dir_a;
      SEL_B_DAT: rd_nxt = rd_b;
      SEL_B_DIR: rd_nxt = dir_b;
      default:   rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_nxt;
  end
endmodule

// File: rtl/pio_dual_port_chk.sv
module pio_dual_port_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              exp_mode,
  input logic [DATA_W-1:0] hi_addr,
  input logic [DATA_W-1:0] pin_out_a,
  input logic [DATA_W-1:0] pin_oe_a,
  input logic [DATA_W-1:0] alt_sel_a,
  input logic [DATA_W-1:0] alt_oe_a,
  input logic [DATA_W-1:0] alt_out_a,
  input logic [DATA_W-1:0] pin_out_b,
  input logic [DATA_W-1:0] pin_oe_b,
  input logic [DATA_W-1:0] dir_a
);
  import pio_pkg::*;
  logic b_hit, mapped;
  assign b_hit  = (bus_addr == ADDR_W'(OFS_B_DAT)) || (bus_addr == ADDR_W'(OFS_B_DIR));
  assign mapped = b_hit || (bus_addr == ADDR_W'(OFS_A_DAT)) || (bus_addr == ADDR_W'(OFS_A_DIR));

  assert_quiet_after_reset_R3: assert property (@(posedge clk)
    rst |=> (pin_oe_a == '0 && pin_oe_b == '0 && pin_out_a == '0 && bus_rdata == '0));

  assert_dir_drives_oe_R2: assert property (@(posedge clk) disable iff (rst)
    (alt_sel_a == '0) |=> (pin_oe_a == $past(dir_a)));

  assert_alt_takes_pin_R6: assert property (@(posedge clk) disable iff (rst)
    (alt_sel_a != '0) |=>
      (((pin_oe_a & $past(alt_sel_a)) == $past(alt_oe_a & alt_sel_a)) &&
       ((pin_out_a & $past(alt_sel_a)) == $past(alt_out_a & alt_sel_a))));

  assert_addr_byte_on_b_R7: assert property (@(posedge clk) disable iff (rst)
    exp_mode |=> (pin_oe_b == {DATA_W{1'b1}} && pin_out_b == $past(hi_addr)));

  assert_b_hidden_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (exp_mode && b_hit) |=> (bus_rdata == '0));

  assert_unmapped_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (!mapped) |=> (bus_rdata == '0));
endmodule

bind pio_dual_port pio_dual_port_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .exp_mode  (exp_mode),
  .hi_addr   (hi_addr),
  .pin_out_a (pin_out_a),
  .pin_oe_a  (pin_oe_a),
  .alt_sel_a (alt_sel_a),
  .alt_oe_a  (alt_oe_a),
  .alt_out_a (alt_out_a),
  .pin_out_b (pin_out_b),
  .pin_oe_b  (pin_oe_b),
  .dir_a     (dir_a)
);

// File: tb/pio_dual_port_tb.sv
`timescale 1ns/1ps
module pio_dual_port_tb_top;
  logic clk = 0;
  always #5 clk = ~clk;

  logic       rst = 1;
  logic [2:0] bus_addr = 0;
  logic       bus_wr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic       exp_mode = 0;
  logic [7:0] hi_addr = 0;
  logic [7:0] pin_in_a = 0, pin_out_a, pin_oe_a, alt_sel_a = 0, alt_oe_a = 0, alt_out_a = 0;
  logic [7:0] pin_in_b = 0, pin_out_b, pin_oe_b, alt_sel_b = 0, alt_oe_b = 0, alt_out_b = 0;

  pio_dual_port dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .exp_mode(exp_mode), .hi_addr(hi_addr),
    .pin_in_a(pin_in_a), .pin_out_a(pin_out_a), .pin_oe_a(pin_oe_a),
    .alt_sel_a(alt_sel_a), .alt_oe_a(alt_oe_a), .alt_out_a(alt_out_a),
    .pin_in_b(pin_in_b), .pin_out_b(pin_out_b), .pin_oe_b(pin_oe_b),
    .alt_sel_b(alt_sel_b), .alt_oe_b(alt_oe_b), .alt_out_b(alt_out_b)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit cmp_on = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge
  logic [7:0] m_adat = 0, m_adir = 0, m_bdat = 0, m_bdir = 0;
  logic [7:0] m_as1 = 0, m_as2 = 0, m_bs1 = 0, m_bs2 = 0;
  logic [7:0] m_rd = 0, m_aout = 0, m_aoe = 0, m_bout = 0, m_boe = 0;
  logic [7:0] t_rd;

  function automatic logic [7:0] merge(input logic [7:0] dir, input logic [7:0] dat,
                                       input logic [7:0] pin);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = dir[i] ? dat[i] : pin[i];
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_adir = 0; m_bdir = 0; m_as1 = 0; m_as2 = 0; m_bs1 = 0; m_bs2 = 0;
      m_rd = 0; m_aout = 0; m_aoe = 0; m_bout = 0; m_boe = 0;
    end else begin
      case (bus_addr)
        3'd0: t_rd = merge(m_adir, m_adat, m_as2);
        3'd1: t_rd = m_adir;
        3'd4: t_rd = exp_mode ? 8'h00 : merge(m_bdir, m_bdat, m_bs2);
        3'd5: t_rd = exp_mode ? 8'h00 : m_bdir;
        default: t_rd = 8'h00;
      endcase
      m_rd = t_rd;
      for (int i = 0; i < 8; i++) begin
        if (alt_sel_a[i]) begin m_aoe[i] = alt_oe_a[i]; m_aout[i] = alt_out_a[i]; end
        else begin m_aoe[i] = m_adir[i]; m_aout[i] = m_adir[i] ? m_adat[i] : 1'b0; end
        if (exp_mode) begin m_boe[i] = 1'b1; m_bout[i] = hi_addr[i]; end
        else if (alt_sel_b[i]) begin m_boe[i] = alt_oe_b[i]; m_bout[i] = alt_out_b[i]; end
        else begin m_boe[i] = m_bdir[i]; m_bout[i] = m_bdir[i] ? m_bdat[i] : 1'b0; end
      end
      if (bus_wr) begin
        case (bus_addr)
          3'd0: m_adat = bus_wdata;
          3'd1: m_adir = bus_wdata;
          3'd4: if (!exp_mode) m_bdat = bus_wdata;
          3'd5: if (!exp_mode) m_bdir = bus_wdata;
          default: ;
        endcase
      end
      m_as2 = m_as1; m_as1 = pin_in_a;
      m_bs2 = m_bs1; m_bs1 = pin_in_b;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check("R5 model bus_rdata", bus_rdata, m_rd);
      check("R2 model pin_oe_a", pin_oe_a, m_aoe);
      check("R2 model pin_out_a", pin_out_a, m_aout);
      check("R7 model pin_oe_b", pin_oe_b, m_boe);
      check("R7 model pin_out_b", pin_out_b, m_bout);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); bus_addr = a; bus_wr = 0;
    @(negedge clk); v = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 0; cmp_on = 1;

    // R3: state after reset
    rd(3'd1, v); check("R3 dir A after reset", v, 8'h00);
    rd(3'd5, v); check("R3 dir B after reset", v, 8'h00);
    check("R3 pin_oe_a after reset", pin_oe_a, 8'h00);
    check("R3 pin_oe_b after reset", pin_oe_b, 8'h00);

    // R1: offsets
    wr(3'd0, 8'hA5); wr(3'd1, 8'h0F); wr(3'd4, 8'h3C); wr(3'd5, 8'hF0);
    @(negedge clk);
    rd(3'd1, v); check("R1 dir A readback", v, 8'h0F);
    rd(3'd5, v); check("R1 dir B readback", v, 8'hF0);

    // R2: direction drives pins
    check("R2 pin_oe_a", pin_oe_a, 8'h0F);
    check("R2 pin_out_a", pin_out_a, 8'h05);
    check("R2 pin_oe_b", pin_oe_b, 8'hF0);
    check("R2 pin_out_b", pin_out_b, 8'h30);

    // R5: synchronized pin read, two-edge delay
    @(negedge clk); bus_addr = 3'd0; pin_in_a = 8'h3C;
    @(negedge clk);
    @(negedge clk); check("R5 read before sync settles", bus_rdata, 8'h05);
    @(negedge clk); check("R5 read after sync", bus_rdata, 8'h35);

    // R10: read latency and write-to-pin latency
    @(negedge clk); bus_addr = 3'd1;
    @(negedge clk); check("R10 read one edge later", bus_rdata, 8'h0F);
    wr(3'd1, 8'hFF);
    check("R10 pins not yet updated", pin_oe_a, 8'h0F);
    @(negedge clk); check("R10 pins updated next edge", pin_oe_a, 8'hFF);

    // R6: alternate function takes selected pins
    @(negedge clk); alt_sel_a = 8'hC3; alt_oe_a = 8'h81; alt_out_a = 8'h01;
    @(negedge clk); @(negedge clk);
    check("R6 alt oe", pin_oe_a, 8'hBD);
    check("R6 alt out", pin_out_a, 8'h25);
    wr(3'd0, 8'h5A); @(negedge clk);
    check("R6 write blocked on alt pins", pin_out_a, 8'h19);
    rd(3'd0, v); check("R6 write stored", v, 8'h5A);
    @(negedge clk); alt_sel_a = 0;

    // R4: latches survive reset
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    check("R3 pin_oe_a after second reset", pin_oe_a, 8'h00);
    rd(3'd1, v); check("R3 dir A cleared", v, 8'h00);
    wr(3'd1, 8'hFF); wr(3'd5, 8'hFF); @(negedge clk);
    check("R4 latch A kept", pin_out_a, 8'h5A);
    check("R4 latch B kept", pin_out_b, 8'h3C);

    // R7: address byte on port B
    @(negedge clk); exp_mode = 1; hi_addr = 8'h9E;
    @(negedge clk);
    check("R7 oe all ones", pin_oe_b, 8'hFF);
    check("R7 address byte", pin_out_b, 8'h9E);

    // R8: port B hidden in address mode
    wr(3'd4, 8'h11); wr(3'd5, 8'h00);
    rd(3'd4, v); check("R8 B data hidden", v, 8'h00);
    rd(3'd5, v); check("R8 B dir hidden", v, 8'h00);
    @(negedge clk); exp_mode = 0;
    rd(3'd5, v); check("R8 B dir kept", v, 8'hFF);
    rd(3'd4, v); check("R8 B data kept", v, 8'h3C);

    // R9: unmapped offsets
    wr(3'd2, 8'h77); wr(3'd7, 8'h77); wr(3'd3, 8'h00); wr(3'd6, 8'h00);
    rd(3'd2, v); check("R9 offset 2 reads zero", v, 8'h00);
    rd(3'd7, v); check("R9 offset 7 reads zero", v, 8'h00);
    rd(3'd1, v); check("R9 dir A untouched", v, 8'hFF);
    rd(3'd0, v); check("R9 data A untouched", v, 8'h5A);
    rd(3'd4, v); check("R9 data B untouched", v, 8'h3C);

    // Random traffic against the model (R1, R2, R5, R6, R7, R8)
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      rst       = ($urandom % 97) == 0;
      bus_addr  = 3'($urandom);
      bus_wr    = $urandom % 2;
      bus_wdata = 8'($urandom);
      exp_mode  = ($urandom % 4) == 0;
      hi_addr   = 8'($urandom);
      pin_in_a  = 8'($urandom);
      pin_in_b  = 8'($urandom);
      alt_sel_a = 8'($urandom) & 8'($urandom);
      alt_oe_a  = 8'($urandom);
      alt_out_a = 8'($urandom);
      alt_sel_b = 8'($urandom) & 8'($urandom);
      alt_oe_b  = 8'($urandom);
      alt_out_b = 8'($urandom);
    end
    @(negedge clk); rst = 0; bus_wr = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule